// File: doc/BRIEF.md
# Weight-Stationary Convolution Systolic Array

This block is the multiply-accumulate core of a convolution layer. A grid of ROWS by COLS processing elements each keeps a small local store of signed 8-bit weights, one per time-step slot. Every cycle a vector of activations can enter, one per row, all taken from the same x,y position. Each row carries a different input feature map. The activations step rightwards one element per cycle. Partial sums step downwards one element per cycle. Each column therefore forms, for its own output feature map, the weighted sum over all rows.

Every column ends in its own 32-bit signed accumulator. A pixel is built from one or more vectors. The first vector of a pixel restarts the accumulator, and the last one publishes the totals. Each vector names the weight slot it uses. Stepping through the slots lets the same multipliers consume more input maps or produce more output maps. When a feature-map depth is not a multiple of the array size, a per-vector row mask zeroes unused rows, and a per-vector column mask suppresses results from unused columns.

Weights are written one at a time, addressed by row, column and slot, while no vector is in flight.

Top module: `ws_conv_array`

## Requirements
- R1: Activations enter at the left edge of each row and move one element right per clock. Row r is delayed by r cycles, so that column sums line up with the diagonal wavefront. A wrong alignment shows up as wrong column totals.
- R2: Each element multiplies the passing activation by the weight held in the slot named by that vector's `act_slot`. The product is a full signed 8x8 product; for example, (-128)·(-128) = 16384.
- R3: For one vector, the contribution to column c is the sum over rows r of act[r]·w[r][c][slot]. Row r occupies bits [8r+7:8r] of `act_data`.
- R4: A valid vector with `vec_first`=1 discards the previous accumulator contents and starts from that vector's own column sums.
- R5: The accumulators add successive valid vectors. While `act_valid`=0, all other vector inputs are ignored and the accumulators hold.
- R6: A valid vector with `vec_last`=1 raises `res_valid[c]` for exactly one cycle. The rise comes ROWS+COLS-1 rising edges after the edge that sampled the vector. `res_data` bits [32c+31:32c] then hold the 32-bit signed total including that vector, and all columns come out in the same cycle.
- R7: If bit c of `col_en` is 0 on the last vector, `res_valid[c]` stays 0 for that pixel.
- R8: If bit r of `row_en` is 0 on a vector, row r contributes zero to every column for that vector.
- R9: A cycle with `wl_en`=1 writes `wl_data` into weight w[`wl_row`][`wl_col`][`wl_slot`]. It changes no other weight. Writes are allowed only while no vector is in flight.
- R10: After reset, all weights and accumulators are zero and `res_valid` is all zero. A pixel whose first vector lacks `vec_first` starts from zero.
- R11: Vectors may arrive on consecutive cycles. Single-vector pixels issued back to back produce results on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wl_en | input | 1 | Weight write strobe |
| wl_row | input | RB | Weight row address |
| wl_col | input | CB | Weight column address |
| wl_slot | input | SB | Weight slot address |
| wl_data | input | 8 | Signed weight value |
| act_valid | input | 1 | Activation vector valid |
| act_data | input | ROWS*8 | One signed activation per row |
| act_slot | input | SB | Weight slot used by this vector |
| row_en | input | ROWS | Per-row enable for this vector |
| vec_first | input | 1 | First vector of a pixel (restart accumulators) |
| vec_last | input | 1 | Last vector of a pixel (publish results) |
| col_en | input | COLS | Per-column result enable, used with the last vector |
| res_valid | output | COLS | Per-column result strobe |
| res_data | output | COLS*32 | Per-column signed totals |

## Verification
A vector sampled on a rising edge contributes to outputs that change on the edge ROWS+COLS-1 later, which is 7 edges at the default size. Each scenario task drives inputs on falling edges. After the last vector it counts exactly that many rising edges. It confirms that `res_valid` is still low one cycle early, checks the totals on the falling edge after the due edge, and confirms that the strobe has dropped one cycle later. For back-to-back pixels, the second result is expected on the very next cycle.

// File: rtl/wsa_pkg.sv
package wsa_pkg;
  parameter int ELEM_W = 8;
  parameter int ACC_W  = 32;

  typedef logic signed [ELEM_W-1:0] elem_t;
  typedef logic signed [ACC_W-1:0]  acc_t;

  // partial sum plus one full-precision signed product
  function automatic acc_t mac(acc_t base, elem_t a, elem_t w);
    return base + (acc_t'(a) * acc_t'(w));
  endfunction

  // restart or extend a running column total
  function automatic acc_t accum_step(logic restart, acc_t acc, acc_t sum);
    return restart ? sum : acc + sum;
  endfunction
endpackage

// File: rtl/wsa_delay.sv
module wsa_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] sr [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
    end else begin
      sr[0] <= d;
      for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
    end
  end

  assign q = sr[DEPTH-1];
endmodule

// File: rtl/wsa_pe.sv
module wsa_pe import wsa_pkg::*; #(
  parameter int SLOTS = 4,
  parameter int SB    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SB-1:0] wr_slot,
  input  elem_t         wr_data,
  input  elem_t         a_in,
  input  logic [SB-1:0] s_in,
  input  acc_t          ps_in,
  output elem_t         a_out,
  output logic [SB-1:0] s_out,
  output acc_t          ps_out
);
  elem_t wmem [SLOTS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) wmem[i] <= '0;
    end else if (wr_en) begin
      wmem[wr_slot] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_out  <= '0;
      s_out  <= '0;
      ps_out <= '0;
    end else begin
      a_out  <= a_in;
      s_out  <= s_in;
      ps_out <= mac(ps_in, a_in, wmem[s_in]);
    end
  end
endmodule

// File: rtl/wsa_colacc.sv
module wsa_colacc import wsa_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic vld,
  input  logic first,
  input  logic last,
  input  logic en,
  input  acc_t sum,
  output acc_t res,
  output logic res_vld
);
  acc_t acc;
  acc_t acc_nxt;
  logic publish;

  assign acc_nxt = accum_step(first, acc, sum);
  assign publish = vld && last && en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      res     <= '0;
      res_vld <= 1'b0;
    end else begin
      res_vld <= publish;
      if (vld) acc <= acc_nxt;
      if (publish) res <= acc_nxt;
    end
  end

  // R5: idle slots leave the running total untouched
  a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |=> $stable(acc));

  // R6/R7: no strobe without an enabled closing vector
  a_r6_no_spurious_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(vld && last && en) |=> !res_vld);
endmodule

// File: rtl/ws_conv_array.sv
module ws_conv_array import wsa_pkg::*; #(
  parameter  int ROWS  = 4,
  parameter  int COLS  = 4,
  parameter  int SLOTS = 4,
  localparam int RB    = (ROWS  > 1) ? $clog2(ROWS)  : 1,
  localparam int CB    = (COLS  > 1) ? $clog2(COLS)  : 1,
  localparam int SB    = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wl_en,
  input  logic [RB-1:0]          wl_row,
  input  logic [CB-1:0]          wl_col,
  input  logic [SB-1:0]          wl_slot,
  input  logic [ELEM_W-1:0]      wl_data,
  input  logic                   act_valid,
  input  logic [ROWS*ELEM_W-1:0] act_data,
  input  logic [SB-1:0]          act_slot,
  input  logic [ROWS-1:0]        row_en,
  input  logic                   vec_first,
  input  logic                   vec_last,
  input  logic [COLS-1:0]        col_en,
  output logic [COLS-1:0]        res_valid,
  output logic [COLS*ACC_W-1:0]  res_data
);
  localparam int LAT = ROWS + COLS - 1;
  localparam int RW  = SB + ELEM_W;
  localparam int CTW = 3 + COLS;
  localparam int CW  = $clog2(LAT + 1);

  elem_t       act_h  [ROWS][COLS+1];
  logic [SB-1:0] slot_h [ROWS][COLS+1];
  acc_t        ps_v   [ROWS+1][COLS];
  acc_t        col_al [COLS];
  logic [CTW-1:0] ctl_in, ctl_al;
  logic [CW-1:0]  busy_cnt;
  logic           busy;

  // rows: input skew and processing elements
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [RW-1:0] raw, skw;
    assign raw = act_valid ? {act_slot, (row_en[r] ? act_data[r*ELEM_W +: ELEM_W] : {ELEM_W{1'b0}})}
                           : '0;
    if (r == 0) begin : g_noskew
      assign skw = raw;
    end else begin : g_skew
      wsa_delay #(.W(RW), .DEPTH(r)) u_skew (.clk(clk), .rst_n(rst_n), .d(raw), .q(skw));
    end
    assign act_h[r][0]  = elem_t'(skw[ELEM_W-1:0]);
    assign slot_h[r][0] = skw[RW-1:ELEM_W];

    for (genvar c = 0; c < COLS; c++) begin : g_col
      logic wr_hit;
      assign wr_hit = wl_en && (wl_row == RB'(r)) && (wl_col == CB'(c));
      wsa_pe #(.SLOTS(SLOTS), .SB(SB)) u_pe (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_hit), .wr_slot(wl_slot), .wr_data(elem_t'(wl_data)),
        .a_in(act_h[r][c]), .s_in(slot_h[r][c]), .ps_in(ps_v[r][c]),
        .a_out(act_h[r][c+1]), .s_out(slot_h[r][c+1]), .ps_out(ps_v[r+1][c]));

      if (c > 0) begin : g_flow
        // R1: element c sees what element c-1 saw one cycle earlier
        a_r1_flow_right: assert property (@(posedge clk) disable iff (!rst_n)
          act_h[r][c+1] == $past(act_h[r][c]));
      end
    end
  end

  // control follows the vector to the bottom of the array
  assign ctl_in = {act_valid, act_valid & vec_first, act_valid & vec_last, col_en};
  wsa_delay #(.W(CTW), .DEPTH(LAT)) u_ctl (.clk(clk), .rst_n(rst_n), .d(ctl_in), .q(ctl_al));

  // columns: deskew and accumulate
  for (genvar c = 0; c < COLS; c++) begin : g_out
    assign ps_v[0][c] = '0;
    if (c == COLS - 1) begin : g_nodsk
      assign col_al[c] = ps_v[ROWS][c];
    end else begin : g_dsk
      logic [ACC_W-1:0] dq;
      wsa_delay #(.W(ACC_W), .DEPTH(COLS-1-c)) u_dsk (
        .clk(clk), .rst_n(rst_n), .d(ps_v[ROWS][c]), .q(dq));
      assign col_al[c] = acc_t'(dq);
    end
    wsa_colacc u_acc (
      .clk(clk), .rst_n(rst_n),
      .vld(ctl_al[CTW-1]), .first(ctl_al[CTW-2]), .last(ctl_al[CTW-3]), .en(ctl_al[c]),
      .sum(col_al[c]), .res(res_data[c*ACC_W +: ACC_W]), .res_vld(res_valid[c]));
  end

  // in-flight tracker used to guard weight writes
  always_ff @(posedge clk) begin
    if (!rst_n) busy_cnt <= '0;
    else if (act_valid) busy_cnt <= CW'(LAT);
    else if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
  end
  assign busy = (busy_cnt != '0);

  // R9: weight writes only while the array is idle
  a_r9_load_idle: assert property (@(posedge clk) disable iff (!rst_n)
    wl_en |-> !(act_valid || busy));
endmodule

// File: tb/ws_conv_array_bench.sv
`timescale 1ns/1ps
module ws_conv_array_bench;
  localparam int ROWS = 4, COLS = 4, SLOTS = 4;
  localparam int LAT = ROWS + COLS - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic wl_en;
  logic [1:0] wl_row, wl_col, wl_slot;
  logic [7:0] wl_data;
  logic act_valid;
  logic [ROWS*8-1:0] act_data;
  logic [1:0] act_slot;
  logic [ROWS-1:0] row_en;
  logic vec_first, vec_last;
  logic [COLS-1:0] col_en;
  logic [COLS-1:0] res_valid;
  logic [COLS*32-1:0] res_data;

  always #2 clk = ~clk;

  ws_conv_array u_ws_conv_array (
    .clk(clk), .rst_n(rst_n), .wl_en(wl_en), .wl_row(wl_row), .wl_col(wl_col),
    .wl_slot(wl_slot), .wl_data(wl_data), .act_valid(act_valid), .act_data(act_data),
    .act_slot(act_slot), .row_en(row_en), .vec_first(vec_first), .vec_last(vec_last),
    .col_en(col_en), .res_valid(res_valid), .res_data(res_data));

  int n_chk = 0, n_bad = 0;
  int wref [ROWS][COLS][SLOTS];
  int exp_acc [COLS];
  int snap [COLS];
  int cur_act [ROWS];

  task automatic chk(string req, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic load_w(int r, int c, int s, int val);
    @(negedge clk);
    wl_en = 1'b1; wl_row = 2'(r); wl_col = 2'(c); wl_slot = 2'(s); wl_data = 8'(val);
    wref[r][c][s] = val;
    @(posedge clk);
    @(negedge clk);
    wl_en = 1'b0;
  endtask

  task automatic set_acts(int seed);
    for (int r = 0; r < ROWS; r++) cur_act[r] = ((seed * 13 + r * 29) % 255) - 127;
  endtask

  task automatic drive_idle();
    act_valid = 1'b0;
    act_data = $urandom; act_slot = 2'($urandom);
    vec_first = 1'($urandom); vec_last = 1'($urandom);
    row_en = 4'($urandom); col_en = 4'($urandom);
  endtask

  task automatic issue(bit vld, bit first, bit last, int slot, logic [ROWS-1:0] ren,
                       logic [COLS-1:0] cen);
    @(negedge clk);
    act_valid = vld; vec_first = first; vec_last = last; act_slot = 2'(slot);
    row_en = ren; col_en = cen;
    for (int r = 0; r < ROWS; r++) act_data[r*8 +: 8] = 8'(cur_act[r]);
    if (vld) begin
      for (int c = 0; c < COLS; c++) begin
        int s = 0;
        for (int r = 0; r < ROWS; r++) if (ren[r]) s += cur_act[r] * wref[r][c][slot];
        exp_acc[c] = first ? s : exp_acc[c] + s;
      end
    end
    @(posedge clk);
  endtask

  task automatic expect_out(string req, logic [COLS-1:0] mask, bit use_snap);
    for (int c = 0; c < COLS; c++) begin
      chk(req, int'(res_valid[c]), int'(mask[c]));
      if (mask[c])
        chk(req, $signed(res_data[c*32 +: 32]), use_snap ? snap[c] : exp_acc[c]);
    end
  endtask

  // after the last vector: silent until due edge, strobe for one cycle only (R6)
  task automatic finish_one(string req, logic [COLS-1:0] mask);
    @(negedge clk); drive_idle();
    repeat (LAT - 1) @(posedge clk);
    @(negedge clk); chk({req, " R6 early"}, int'(res_valid), 0);
    @(posedge clk);
    @(negedge clk); expect_out(req, mask, 1'b0);
    @(posedge clk);
    @(negedge clk); chk({req, " R6 one-cycle"}, int'(res_valid), 0);
  endtask

  task automatic t_reset_start();
    chk("R10 reset valid", int'(res_valid), 0);
    chk("R10 reset data", int'(res_data[31:0]), 0);
    set_acts(3);
    issue(1, 0, 1, 0, 4'hF, 4'hF);   // no vec_first: accumulators start at zero
    finish_one("R10 zero weights/acc", 4'hF);
  endtask

  task automatic t_single();
    set_acts(7);
    issue(1, 1, 1, 0, 4'hF, 4'hF);
    finish_one("R1 R2 R3 single vector", 4'hF);
  endtask

  task automatic t_multi_step();
    for (int s = 0; s < SLOTS; s++) begin
      set_acts(11 + s);
      issue(1, s == 0, s == SLOTS - 1, s, 4'hF, 4'hF);
    end
    finish_one("R2 R5 slot stepping", 4'hF);
  endtask

  task automatic t_restart();
    set_acts(21); issue(1, 1, 0, 1, 4'hF, 4'hF);
    set_acts(22); issue(1, 0, 0, 2, 4'hF, 4'hF);
    set_acts(23); issue(1, 1, 1, 3, 4'hF, 4'hF);  // restart discards the two above
    finish_one("R4 restart", 4'hF);
  endtask

  task automatic t_gap();
    set_acts(31); issue(1, 1, 0, 0, 4'hF, 4'hF);
    set_acts(99); issue(0, 1, 1, 2, 4'hF, 4'hF);  // invalid: must be ignored
    set_acts(98); issue(0, 0, 1, 1, 4'hF, 4'hF);
    set_acts(32); issue(1, 0, 1, 1, 4'hF, 4'hF);
    finish_one("R5 ignored idle vectors", 4'hF);
  endtask

  task automatic t_row_mask();
    set_acts(41); issue(1, 1, 0, 0, 4'b0101, 4'hF);
    set_acts(42); issue(1, 0, 1, 3, 4'b0011, 4'hF);
    finish_one("R8 row mask", 4'hF);
  endtask

  task automatic t_col_mask();
    set_acts(51); issue(1, 1, 0, 2, 4'hF, 4'hF);
    set_acts(52); issue(1, 0, 1, 1, 4'hF, 4'b1010);
    finish_one("R7 column mask", 4'b1010);
  endtask

  task automatic t_back_to_back();
    set_acts(61); issue(1, 1, 1, 0, 4'hF, 4'hF);
    for (int c = 0; c < COLS; c++) snap[c] = exp_acc[c];
    set_acts(62); issue(1, 1, 1, 2, 4'hF, 4'hF);
    @(negedge clk); drive_idle();
    repeat (LAT - 2) @(posedge clk);
    @(negedge clk); chk("R11 early", int'(res_valid), 0);
    @(posedge clk);
    @(negedge clk); expect_out("R11 first pixel", 4'hF, 1'b1);
    @(posedge clk);
    @(negedge clk); expect_out("R11 second pixel", 4'hF, 1'b0);
    @(posedge clk);
    @(negedge clk); chk("R11 R6 strobe drop", int'(res_valid), 0);
  endtask

  task automatic t_rewrite();
    load_w(1, 2, 3, 77);
    set_acts(71); issue(1, 1, 1, 3, 4'hF, 4'hF);
    finish_one("R9 rewritten slot", 4'hF);
    set_acts(72); issue(1, 1, 1, 2, 4'hF, 4'hF);
    finish_one("R9 neighbour slot unchanged", 4'hF);
  endtask

  task automatic t_extremes();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) load_w(r, c, 0, (c == 3) ? 127 : -128);
    for (int r = 0; r < ROWS; r++) cur_act[r] = -128;
    for (int k = 0; k < 4; k++) issue(1, k == 0, k == 3, 0, 4'hF, 4'hF);
    finish_one("R2 extreme products", 4'hF);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wl_en = 1'b0; wl_row = '0; wl_col = '0; wl_slot = '0; wl_data = '0;
    act_valid = 1'b0; act_data = '0; act_slot = '0; row_en = '0;
    vec_first = 1'b0; vec_last = 1'b0; col_en = '0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        for (int s = 0; s < SLOTS; s++) wref[r][c][s] = 0;
    for (int c = 0; c < COLS; c++) exp_acc[c] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset_start();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        for (int s = 0; s < SLOTS; s++) load_w(r, c, s, ((r * 5 + c * 3 + s * 7 + 1) % 19) - 9);
    t_single();
    t_multi_step();
    t_restart();
    t_gap();
    t_row_mask();
    t_col_mask();
    t_back_to_back();
    t_rewrite();
    t_extremes();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule